// File: doc/BRIEF.md
# Receive Buffer Flow-Control Watermark Controller

This block sits beside the receive buffer of an Ethernet MAC and decides when the link partner must be told to stop sending and when it may start again. It watches the buffer occupancy in bytes and compares it with two thresholds. The thresholds are programmed in 8-byte units, and a high threshold of zero turns off generation of stop requests. When the occupancy rises above the high threshold, the block sends a single stop request that carries a fixed pause time, 0xF000 by default. When the occupancy then drops under the low threshold, it sends a single resume request that carries a pause time of zero. The frame builder downstream turns these requests into PAUSE frames.

The block also honours PAUSE frames sent by the partner. When an enable bit is set, a received pause holds the local transmitter for quanta × 512 bit times. That time is converted to clock cycles using the number of bits the datapath moves per clock. A third function counts received frames whose length is above a programmed maximum. That length includes the header and excludes the FCS.

Top module: `pause_wm_ctrl`

## Requirements
- R1: After reset, `xoff_req`, `xon_req` and `tx_hold` are low, `req_quanta` is zero, the watermark state is "running", and `oversize_cnt` is zero.
- R2: When the block is running and `cfg_hwm` is nonzero, `xoff_req` pulses for one cycle, one cycle after `fifo_level` becomes strictly greater than `cfg_hwm`×8. In that cycle `req_quanta` equals PAUSE_TIME (default 0xF000). A level equal to `cfg_hwm`×8 causes no request.
- R3: After a stop request, no further `xoff_req` is issued while the occupancy stays high. A new stop request can only follow a resume request.
- R4: When the block has sent a stop request, `xon_req` pulses for one cycle, one cycle after `fifo_level` becomes strictly less than `cfg_lwm`×8. In that cycle `req_quanta` is zero. A level equal to `cfg_lwm`×8 causes no request.
- R5: When `cfg_hwm` is zero, `xoff_req` is never raised, whatever the level.
- R6: If `cfg_hwm` becomes zero after a stop request, `xon_req` pulses one cycle later.
- R7: `xoff_req` and `xon_req` are never high in the same cycle.
- R8: With `cfg_honor_pause` high, a one-cycle `rx_pause_vld` carrying a nonzero quanta Q raises `tx_hold` in the next cycle and keeps it high for exactly Q×512/BITS_PER_CYC cycles. That is Q×8 cycles at the default of 64 bits per cycle.
- R9: A received pause with zero quanta drops `tx_hold` in the next cycle.
- R10: When `cfg_honor_pause` is low, received pauses do not raise `tx_hold`. Clearing `cfg_honor_pause` during a hold drops `tx_hold` in the next cycle.
- R11: A pause received while a hold is running restarts the hold with the new quanta.
- R12: A `frm_end_vld` with `frm_len` strictly greater than `cfg_max_len` raises `oversize_cnt` by one in the next cycle. A length equal to or below the maximum leaves the counter unchanged.
- R13: `oversize_cnt` saturates at its all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_level | input | LVL_W | Receive buffer occupancy in bytes |
| cfg_lwm | input | WM_W | Low threshold, 8-byte units |
| cfg_hwm | input | WM_W | High threshold, 8-byte units; zero disables stop requests |
| cfg_honor_pause | input | 1 | Received pauses stall the transmitter when high |
| cfg_max_len | input | LEN_W | Largest legal frame length, header included, FCS excluded |
| rx_pause_vld | input | 1 | Strobe: a pause frame was received |
| rx_pause_quanta | input | Q_W | Pause time of the received frame, 512-bit-time units |
| frm_end_vld | input | 1 | Strobe: a received frame ended |
| frm_len | input | LEN_W | Length of that frame |
| xoff_req | output | 1 | One-cycle stop request |
| xon_req | output | 1 | One-cycle resume request |
| req_quanta | output | Q_W | Pause time for the current request |
| tx_hold | output | 1 | Transmitter must hold |
| oversize_cnt | output | CNT_W | Saturating count of oversize frames |

## Verification
Every result is registered once. Stop and resume requests, together with their pause time, appear one cycle after the level or threshold that causes them. `tx_hold` rises or falls one cycle after a pause strobe or a change of the enable bit, and the oversize count moves one cycle after the frame-end strobe. The bench changes inputs on the falling edge and samples one rising edge later, at the next falling edge. For hold lengths it counts the falling edges at which `tx_hold` is still high, so that count equals the number of cycles the hold lasts.

// File: rtl/pause_wm_pkg.sv
package pause_wm_pkg;

    // Watermark hysteresis state
    typedef enum logic {
        WM_RUN    = 1'b0,
        WM_PAUSED = 1'b1
    } wm_state_e;

    // Bit times covered by one pause quantum
    localparam int unsigned BITS_PER_QUANTUM = 512;

endpackage

// File: rtl/wm_req_gen.sv
module wm_req_gen
    import pause_wm_pkg::*;
#(
    parameter int unsigned LVL_W      = 16,
    parameter int unsigned WM_W       = 13,
    parameter int unsigned Q_W        = 16,
    parameter logic [Q_W-1:0] PAUSE_TIME = 16'hF000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] level,
    input  logic [WM_W-1:0]  lwm,
    input  logic [WM_W-1:0]  hwm,
    output logic             xoff,
    output logic             xon,
    output logic [Q_W-1:0]   quanta
);

    localparam int unsigned WMB_W = WM_W + 3;
    localparam int unsigned CMP_W = (LVL_W > WMB_W) ? LVL_W : WMB_W;

    typedef struct packed {
        wm_state_e      state;
        logic           xoff;
        logic           xon;
        logic [Q_W-1:0] quanta;
    } wm_st_t;

    wm_st_t st_d, st_q;

    logic [CMP_W-1:0] lvl_c, hwm_b, lwm_b;
    logic             gen_on;

    always_comb begin
        lvl_c  = CMP_W'(level);
        hwm_b  = CMP_W'({hwm, 3'b000});
        lwm_b  = CMP_W'({lwm, 3'b000});
        gen_on = (hwm != '0);

        st_d        = st_q;
        st_d.xoff   = 1'b0;
        st_d.xon    = 1'b0;
        st_d.quanta = '0;

        unique case (st_q.state)
            WM_RUN: begin
                if (gen_on && (lvl_c > hwm_b)) begin
                    st_d.state  = WM_PAUSED;
                    st_d.xoff   = 1'b1;
                    st_d.quanta = PAUSE_TIME;
                end
            end
            WM_PAUSED: begin
                if (!gen_on || (lvl_c < lwm_b)) begin
                    st_d.state = WM_RUN;
                    st_d.xon   = 1'b1;
                end
            end
            default: st_d.state = WM_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.state  <= WM_RUN;
            st_q.xoff   <= 1'b0;
            st_q.xon    <= 1'b0;
            st_q.quanta <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign xoff   = st_q.xoff;
    assign xon    = st_q.xon;
    assign quanta = st_q.quanta;

endmodule

// File: rtl/peer_hold_timer.sv
module peer_hold_timer
    import pause_wm_pkg::*;
#(
    parameter int unsigned Q_W          = 16,
    parameter int unsigned BITS_PER_CYC = 64
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           honor,
    input  logic           pause_vld,
    input  logic [Q_W-1:0] pause_quanta,
    output logic           hold
);

    localparam int unsigned QUANTUM_CYC = BITS_PER_QUANTUM / BITS_PER_CYC;
    localparam int unsigned Q_SHIFT     = $clog2(QUANTUM_CYC);
    localparam int unsigned TMR_W       = Q_W + Q_SHIFT + 1;

    typedef struct packed {
        logic [TMR_W-1:0] cnt;
    } tmr_st_t;

    tmr_st_t          st_d, st_q;
    logic [TMR_W-1:0] load_val;

    generate
        if ((QUANTUM_CYC & (QUANTUM_CYC - 1)) == 0) begin : g_shift
            assign load_val = TMR_W'(pause_quanta) << Q_SHIFT;
        end else begin : g_mult
            assign load_val = TMR_W'(pause_quanta) * TMR_W'(QUANTUM_CYC);
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (!honor) begin
            st_d.cnt = '0;
        end else if (pause_vld) begin
            st_d.cnt = load_val;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - TMR_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hold = (st_q.cnt != '0);

endmodule

// File: rtl/frame_len_check.sv
module frame_len_check #(
    parameter int unsigned LEN_W = 14,
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             end_vld,
    input  logic [LEN_W-1:0] len,
    input  logic [LEN_W-1:0] max_len,
    output logic [CNT_W-1:0] cnt
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } len_st_t;

    len_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (end_vld && (len > max_len) && (st_q.cnt != '1)) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;

endmodule

// File: rtl/pause_wm_ctrl.sv
module pause_wm_ctrl #(
    parameter int unsigned LVL_W        = 16,
    parameter int unsigned WM_W         = 13,
    parameter int unsigned Q_W          = 16,
    parameter int unsigned LEN_W        = 14,
    parameter int unsigned CNT_W        = 16,
    parameter int unsigned BITS_PER_CYC = 64,
    parameter logic [Q_W-1:0] PAUSE_TIME = 16'hF000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic [WM_W-1:0]  cfg_lwm,
    input  logic [WM_W-1:0]  cfg_hwm,
    input  logic             cfg_honor_pause,
    input  logic [LEN_W-1:0] cfg_max_len,
    input  logic             rx_pause_vld,
    input  logic [Q_W-1:0]   rx_pause_quanta,
    input  logic             frm_end_vld,
    input  logic [LEN_W-1:0] frm_len,
    output logic             xoff_req,
    output logic             xon_req,
    output logic [Q_W-1:0]   req_quanta,
    output logic             tx_hold,
    output logic [CNT_W-1:0] oversize_cnt
);

    wm_req_gen #(
        .LVL_W      (LVL_W),
        .WM_W       (WM_W),
        .Q_W        (Q_W),
        .PAUSE_TIME (PAUSE_TIME)
    ) u_wm (
        .clk    (clk),
        .rst_n  (rst_n),
        .level  (fifo_level),
        .lwm    (cfg_lwm),
        .hwm    (cfg_hwm),
        .xoff   (xoff_req),
        .xon    (xon_req),
        .quanta (req_quanta)
    );

    peer_hold_timer #(
        .Q_W          (Q_W),
        .BITS_PER_CYC (BITS_PER_CYC)
    ) u_hold (
        .clk          (clk),
        .rst_n        (rst_n),
        .honor        (cfg_honor_pause),
        .pause_vld    (rx_pause_vld),
        .pause_quanta (rx_pause_quanta),
        .hold         (tx_hold)
    );

    frame_len_check #(
        .LEN_W (LEN_W),
        .CNT_W (CNT_W)
    ) u_len (
        .clk     (clk),
        .rst_n   (rst_n),
        .end_vld (frm_end_vld),
        .len     (frm_len),
        .max_len (cfg_max_len),
        .cnt     (oversize_cnt)
    );

endmodule

// File: rtl/pause_wm_ctrl_chk.sv
module pause_wm_ctrl_chk #(
    parameter int unsigned WM_W  = 13,
    parameter int unsigned Q_W   = 16,
    parameter int unsigned CNT_W = 16,
    parameter logic [Q_W-1:0] PAUSE_TIME = 16'hF000
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WM_W-1:0]  cfg_hwm,
    input logic             cfg_honor_pause,
    input logic             rx_pause_vld,
    input logic [Q_W-1:0]   rx_pause_quanta,
    input logic             xoff_req,
    input logic             xon_req,
    input logic [Q_W-1:0]   req_quanta,
    input logic             tx_hold,
    input logic [CNT_W-1:0] oversize_cnt
);

    p_req_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(xoff_req && xon_req));

    p_xoff_time_r2: assert property (@(posedge clk) disable iff (!rst_n)
        xoff_req |-> (req_quanta == PAUSE_TIME));

    p_xoff_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        xoff_req |=> !xoff_req);

    p_xon_time_r4: assert property (@(posedge clk) disable iff (!rst_n)
        xon_req |-> (req_quanta == '0));

    p_xoff_needs_hwm_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_hwm == '0) |=> !xoff_req);

    p_zero_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pause_vld && cfg_honor_pause && (rx_pause_quanta == '0)) |=> !tx_hold);

    p_honor_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_honor_pause |=> !tx_hold);

    p_cnt_step_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (oversize_cnt != $past(oversize_cnt)) |->
        (oversize_cnt == ($past(oversize_cnt) + CNT_W'(1))));

endmodule

bind pause_wm_ctrl pause_wm_ctrl_chk #(
    .WM_W       (WM_W),
    .Q_W        (Q_W),
    .CNT_W      (CNT_W),
    .PAUSE_TIME (PAUSE_TIME)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .cfg_hwm         (cfg_hwm),
    .cfg_honor_pause (cfg_honor_pause),
    .rx_pause_vld    (rx_pause_vld),
    .rx_pause_quanta (rx_pause_quanta),
    .xoff_req        (xoff_req),
    .xon_req         (xon_req),
    .req_quanta      (req_quanta),
    .tx_hold         (tx_hold),
    .oversize_cnt    (oversize_cnt)
);

// File: tb/pause_wm_ctrl_tb.sv
module pause_wm_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] fifo_level = '0;
    logic [12:0] cfg_lwm = '0;
    logic [12:0] cfg_hwm = '0;
    logic        cfg_honor_pause = 1'b0;
    logic [13:0] cfg_max_len = '0;
    logic        rx_pause_vld = 1'b0;
    logic [15:0] rx_pause_quanta = '0;
    logic        frm_end_vld = 1'b0;
    logic [13:0] frm_len = '0;
    logic        xoff_req, xon_req, tx_hold;
    logic [15:0] req_quanta;
    logic [CNT_W-1:0] oversize_cnt;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pause_wm_ctrl #(.CNT_W(CNT_W)) u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .fifo_level      (fifo_level),
        .cfg_lwm         (cfg_lwm),
        .cfg_hwm         (cfg_hwm),
        .cfg_honor_pause (cfg_honor_pause),
        .cfg_max_len     (cfg_max_len),
        .rx_pause_vld    (rx_pause_vld),
        .rx_pause_quanta (rx_pause_quanta),
        .frm_end_vld     (frm_end_vld),
        .frm_len         (frm_len),
        .xoff_req        (xoff_req),
        .xon_req         (xon_req),
        .req_quanta      (req_quanta),
        .tx_hold         (tx_hold),
        .oversize_cnt    (oversize_cnt)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic pause_rx(input logic [15:0] q);
        rx_pause_vld    = 1'b1;
        rx_pause_quanta = q;
        step();
        rx_pause_vld    = 1'b0;
    endtask

    task automatic count_hold(output int n);
        n = 0;
        while (tx_hold && n < 1000) begin
            n++;
            step();
        end
    endtask

    task automatic t_reset;
        chk("R1 xoff", xoff_req, 0);
        chk("R1 xon", xon_req, 0);
        chk("R1 quanta", req_quanta, 0);
        chk("R1 hold", tx_hold, 0);
        chk("R1 cnt", oversize_cnt, 0);
    endtask

    task automatic t_xoff;
        cfg_hwm = 13'd100;
        cfg_lwm = 13'd72;
        fifo_level = 16'd800;
        step();
        chk("R2 equal no xoff", xoff_req, 0);
        fifo_level = 16'd801;
        step();
        chk("R2 xoff", xoff_req, 1);
        chk("R2 quanta", req_quanta, 32'hF000);
        step();
        chk("R3 single pulse", xoff_req, 0);
        fifo_level = 16'd2000;
        step(3);
        chk("R3 no repeat", xoff_req, 0);
    endtask

    task automatic t_xon;
        fifo_level = 16'd576;
        step();
        chk("R4 equal no xon", xon_req, 0);
        fifo_level = 16'd575;
        step();
        chk("R4 xon", xon_req, 1);
        chk("R4 quanta", req_quanta, 0);
        chk("R7 xoff low", xoff_req, 0);
        step();
        chk("R4 single pulse", xon_req, 0);
        fifo_level = 16'd801;
        step();
        chk("R3 rearmed", xoff_req, 1);
    endtask

    task automatic t_disable;
        cfg_hwm = '0;
        step();
        chk("R6 xon on disable", xon_req, 1);
        fifo_level = 16'd5000;
        for (int i = 0; i < 4; i++) begin
            step();
            chk("R5 no xoff", xoff_req, 0);
        end
        fifo_level = 16'd100;
        cfg_hwm = 13'd100;
        step();
    endtask

    task automatic t_hold;
        int n;
        cfg_honor_pause = 1'b1;
        pause_rx(16'd3);
        chk("R8 hold raised", tx_hold, 1);
        count_hold(n);
        chk("R8 hold length", n, 24);
    endtask

    task automatic t_zero;
        pause_rx(16'd10);
        step(5);
        chk("R9 hold before", tx_hold, 1);
        pause_rx(16'd0);
        chk("R9 zero release", tx_hold, 0);
    endtask

    task automatic t_restart;
        int n;
        pause_rx(16'd2);
        step(9);
        pause_rx(16'd1);
        count_hold(n);
        chk("R11 restart length", n, 8);
    endtask

    task automatic t_honor_off;
        cfg_honor_pause = 1'b0;
        pause_rx(16'd5);
        chk("R10 ignored", tx_hold, 0);
        step(2);
        chk("R10 still low", tx_hold, 0);
        cfg_honor_pause = 1'b1;
        pause_rx(16'd5);
        step(2);
        chk("R10 hold on", tx_hold, 1);
        cfg_honor_pause = 1'b0;
        step();
        chk("R10 cleared", tx_hold, 0);
    endtask

    task automatic t_oversize;
        cfg_max_len = 14'd1514;
        frm_end_vld = 1'b1;
        frm_len = 14'd1514;
        step();
        frm_end_vld = 1'b0;
        chk("R12 equal", oversize_cnt, 0);
        frm_end_vld = 1'b1;
        frm_len = 14'd1515;
        step();
        frm_end_vld = 1'b0;
        chk("R12 over", oversize_cnt, 1);
        frm_end_vld = 1'b1;
        frm_len = 14'd60;
        step();
        frm_end_vld = 1'b0;
        chk("R12 short", oversize_cnt, 1);
        frm_len = 14'd9000;
        step();
        chk("R12 no strobe", oversize_cnt, 1);
        frm_end_vld = 1'b1;
        step();
        frm_end_vld = 1'b0;
        chk("R12 jumbo", oversize_cnt, 2);
        frm_end_vld = 1'b1;
        step(20);
        frm_end_vld = 1'b0;
        chk("R13 saturate", oversize_cnt, 15);
    endtask

    initial begin
        step(3);
        t_reset();
        rst_n = 1'b1;
        step();
        t_reset();
        t_xoff();
        t_xon();
        t_disable();
        t_hold();
        t_zero();
        t_restart();
        t_honor_off();
        t_oversize();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule